// File: doc/BRIEF.md
# Codec serial host port controller

This block is the digital side of a voice-band codec's serial host port. Once per frame it moves one 16-bit word from the host on `din`, meant for the playback converter, and one 16-bit capture result from `txWord` out on `dout`. It derives the bit clock `sclk` from the system clock. In master mode it makes the active-low frame sync itself. In slave mode it follows a frame sync applied on `fsIn`. A slot select places the word in the first or the second group of sixteen bit periods after the frame edge.

In software control mode, bit 0 of each received word marks it as a data word or as a control word. A control word writes a small bank of 7-bit control registers. The next frame then returns the written value on `dout` in place of the capture word. In hardware control mode, every received word is data. Reset puts the registers in a known state, and frames alternate between primary and secondary, starting with primary. A power-down input freezes the port and keeps the programmed state.

Top module: `codec_host_port`

## Requirements
- R1: With `masterSel`=1, the first `sclk` rising edge after reset starts a frame. A new frame starts every `FRAME_BITS` rising edges. `fsOut` goes low on the rising edge that starts a frame and returns high on the next rising edge, so it is low for exactly one bit period.
- R2: With `masterSel`=0, a frame starts on the `sclk` rising edge at which `fsIn` is sampled low after being sampled high on the previous rising edge. `fsOut` stays high.
- R3: With `slotSel`=0 latched at the frame start, the word occupies bit periods 0 to 15 (period 0 begins at the frame-start rising edge). `dout` changes only on `sclk` rising edges and sends the outgoing word MSB first. `din` is sampled on `sclk` falling edges, MSB first.
- R4: With `slotSel`=1, the word occupies bit periods 16 to 31. In every bit period outside the active slot, `dout` is 0.
- R5: A received data word appears on `rxWord`, and `rxValid` is high for one clock cycle, one clock after the falling edge of the word's last bit. `rxSecondary` is 0 for the first frame after reset and alternates on each later frame.
- R6: If both `hwCtl` bits are 0 when the frame sync rises, the port is in software mode. In software mode a word with bit 0 = 1 is a control word: bits [15:8] are the address and bits [7:1] are the value. The value is written to the register at that address (addresses 0 to `NUM_REGS`-1) when the next frame starts. A control word does not raise `rxValid`.
- R7: In the frame after a control word, `dout` sends {address, value, 1} in place of `txWord`. For an address at or above `NUM_REGS`, no register changes and the value field sent is 0.
- R8: Any nonzero `hwCtl` at the frame-sync rise selects hardware mode. Every word is then delivered as data, whatever its bit 0, and no register changes.
- R9: Reset sets register 0 (half the oversampling ratio) to 80, register 1 (playback attenuation) to 127 (mute), register 2 (capture gain) to 0, and register 3 (input config: bit 0 differential, bit 1 auxiliary mux) to 1. Reset also sets `dout`=0 and `fsOut`=1.
- R10: While `pwrDownN` is low, `sclk` and all registers hold their values. When it returns high, the transfer in progress continues from the point where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterSel | input | 1 | 1 = generate frame sync, 0 = follow `fsIn` |
| slotSel | input | 1 | 0 = first slot, 1 = second slot; latched at frame start |
| hwCtl | input | 2 | Control-mode pins; latched at frame-sync rise |
| pwrDownN | input | 1 | Low freezes the port |
| fsIn | input | 1 | External frame sync, active low (slave mode) |
| din | input | 1 | Serial data from the host |
| txWord | input | 16 | Capture word; sampled at frame start |
| sclk | output | 1 | Serial bit clock |
| fsOut | output | 1 | Generated frame sync, active low |
| dout | output | 1 | Serial data to the host |
| rxWord | output | 16 | Last received data word |
| rxValid | output | 1 | One-cycle strobe for `rxWord` |
| rxSecondary | output | 1 | Frame parity of `rxWord`: 0 primary, 1 secondary |
| ctlRegs | output | NUM_REGS*7 | Control registers; register i at bits [7i+6:7i] |

## Verification
The checks assume that `masterSel` changes only while reset is asserted, and that an external frame sync is low for one bit period and is driven between `sclk` edges. They also assume that `txWord` is steady at each frame start. The bench changes mode pins only inside a reset. It drives `fsIn`, `din` and `txWord` two nanoseconds after a bit-clock edge, never on one. It asserts power-down only between bit-clock edges, in the middle of a slot.

// File: rtl/chp_pkg.sv
`timescale 1ns/1ps
package chp_pkg;
  localparam int WORD_BITS = 16;
  localparam int ADDR_BITS = 8;
  localparam int VAL_BITS  = 7;

  // strobes from the frame control to the datapath, one clock wide
  typedef struct packed {
    logic frameStart;  // sclk rise that opens a frame
    logic shiftOut;    // sclk rise inside the slot: present next dout bit
    logic idleOut;     // sclk rise outside the slot: park dout low
    logic shiftIn;     // sclk fall inside the slot: take din
    logic wordDone;    // shiftIn of the last slot bit
    logic softMode;    // level: software control latched this frame
    logic secondary;   // level: parity of the current frame
  } chp_strobe_t;
endpackage

// File: rtl/chp_ctrl.sv
`timescale 1ns/1ps
module chp_ctrl
  import chp_pkg::*;
#(
  parameter int FRAME_BITS  = 40,
  parameter int HALF_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        masterSel,
  input  logic        slotSel,
  input  logic [1:0]  hwCtl,
  input  logic        pwrDownN,
  input  logic        fsIn,
  output logic        sclk,
  output logic        fsOut,
  output chp_strobe_t stb
);
  localparam int CW  = $clog2(FRAME_BITS) + 1;
  localparam int HCW = $clog2(HALF_CYCLES) + 1;
  localparam logic [CW-1:0]  LAST     = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0]  SAT      = '1;
  localparam logic [HCW-1:0] HALF_END = HCW'(HALF_CYCLES - 1);
  localparam logic [CW-1:0]  SLOT_LEN = CW'(WORD_BITS);

  // bit clock generator
  logic [HCW-1:0] halfCnt;
  logic sclkQ, tick, riseStb, fallStb;

  assign tick    = pwrDownN && (halfCnt == HALF_END);
  assign riseStb = tick && !sclkQ;
  assign fallStb = tick && sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      sclkQ   <= 1'b0;
    end else if (pwrDownN) begin
      if (tick) begin
        halfCnt <= '0;
        sclkQ   <= ~sclkQ;
      end else begin
        halfCnt <= halfCnt + HCW'(1);
      end
    end
  end

  // frame state
  logic [CW-1:0] bitCnt, cntInc, nextCnt;
  logic active, activeNext, fsPrev, fsOutQ, slotQ, slotNext, softQ, parity;
  logic startNow, fsRiseNow;

  function automatic logic [CW-1:0] slotBase(input logic s);
    return s ? SLOT_LEN : '0;
  endfunction

  function automatic logic inSlot(input logic [CW-1:0] c, input logic s);
    return (c >= slotBase(s)) && (c < slotBase(s) + SLOT_LEN);
  endfunction

  always_comb begin
    cntInc = (bitCnt == SAT) ? SAT : bitCnt + CW'(1);
    if (masterSel) begin
      startNow  = (bitCnt == LAST);
      fsRiseNow = active && (bitCnt == '0);
    end else begin
      startNow  = fsPrev && !fsIn;
      fsRiseNow = active && !fsPrev && fsIn;
    end
    nextCnt    = startNow ? '0 : cntInc;
    activeNext = active || startNow;
    slotNext   = startNow ? slotSel : slotQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= masterSel ? LAST : SAT;
      active <= 1'b0;
      fsPrev <= 1'b1;
      fsOutQ <= 1'b1;
      slotQ  <= 1'b0;
      softQ  <= 1'b1;
      parity <= 1'b1;
    end else if (riseStb) begin
      bitCnt <= nextCnt;
      active <= activeNext;
      slotQ  <= slotNext;
      fsPrev <= fsIn;
      fsOutQ <= masterSel ? !startNow : 1'b1;
      if (startNow)  parity <= ~parity;
      if (fsRiseNow) softQ  <= (hwCtl == 2'b00);
    end
  end

  always_comb begin
    stb            = '0;
    stb.frameStart = riseStb && startNow;
    stb.shiftOut   = riseStb && activeNext && inSlot(nextCnt, slotNext);
    stb.idleOut    = riseStb && !stb.shiftOut;
    stb.shiftIn    = fallStb && active && inSlot(bitCnt, slotQ);
    stb.wordDone   = stb.shiftIn && (bitCnt == slotBase(slotQ) + SLOT_LEN - CW'(1));
    stb.softMode   = softQ;
    stb.secondary  = parity;
  end

  assign sclk  = sclkQ;
  assign fsOut = fsOutQ;
endmodule

// File: rtl/chp_dp.sv
`timescale 1ns/1ps
module chp_dp
  import chp_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  chp_strobe_t                  stb,
  input  logic                         din,
  input  logic [WORD_BITS-1:0]         txWord,
  output logic                         dout,
  output logic [WORD_BITS-1:0]         rxWord,
  output logic                         rxValid,
  output logic                         rxSecondary,
  output logic [NUM_REGS*VAL_BITS-1:0] ctlRegs
);
  logic [WORD_BITS-1:0] txShift, rxShift, inWord, readWord, loadWord, srcWord;
  logic [ADDR_BITS-1:0] pendAddr;
  logic [VAL_BITS-1:0]  pendVal;
  logic pendWr, doutQ, addrOk, isCtl;
  logic [VAL_BITS-1:0] regQ [NUM_REGS];

  function automatic logic [VAL_BITS-1:0] defaultVal(input int idx);
    case (idx)
      0:       return VAL_BITS'(80);   // half of ratio 160
      1:       return '1;              // mute
      3:       return VAL_BITS'(1);    // differential, main inputs
      default: return '0;
    endcase
  endfunction

  always_comb begin
    addrOk   = (32'(pendAddr) < NUM_REGS);
    readWord = {pendAddr, (addrOk ? pendVal : '0), 1'b1};
    loadWord = pendWr ? readWord : txWord;
    srcWord  = stb.frameStart ? loadWord : txShift;
    inWord   = {rxShift[WORD_BITS-2:0], din};
    isCtl    = stb.softMode && inWord[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift     <= '0;
      rxShift     <= '0;
      doutQ       <= 1'b0;
      pendWr      <= 1'b0;
      pendAddr    <= '0;
      pendVal     <= '0;
      rxWord      <= '0;
      rxValid     <= 1'b0;
      rxSecondary <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.shiftOut) begin
        doutQ   <= srcWord[WORD_BITS-1];
        txShift <= {srcWord[WORD_BITS-2:0], 1'b0};
      end else if (stb.frameStart) begin
        txShift <= srcWord;
      end
      if (stb.idleOut)    doutQ  <= 1'b0;
      if (stb.frameStart) pendWr <= 1'b0;
      if (stb.shiftIn)    rxShift <= inWord;
      if (stb.wordDone) begin
        if (isCtl) begin
          pendWr   <= 1'b1;
          pendAddr <= inWord[WORD_BITS-1 -: ADDR_BITS];
          pendVal  <= inWord[VAL_BITS:1];
        end else begin
          rxWord      <= inWord;
          rxValid     <= 1'b1;
          rxSecondary <= stb.secondary;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[i] <= defaultVal(i);
      else if (stb.frameStart && pendWr && (pendAddr == ADDR_BITS'(i)))
        regQ[i] <= pendVal;
    end
    assign ctlRegs[i*VAL_BITS +: VAL_BITS] = regQ[i];
  end

  assign dout = doutQ;
endmodule

// File: rtl/codec_host_port.sv
`timescale 1ns/1ps
module codec_host_port
  import chp_pkg::*;
#(
  parameter int FRAME_BITS  = 40,
  parameter int HALF_CYCLES = 2,
  parameter int NUM_REGS    = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         masterSel,
  input  logic                         slotSel,
  input  logic [1:0]                   hwCtl,
  input  logic                         pwrDownN,
  input  logic                         fsIn,
  input  logic                         din,
  input  logic [15:0]                  txWord,
  output logic                         sclk,
  output logic                         fsOut,
  output logic                         dout,
  output logic [15:0]                  rxWord,
  output logic                         rxValid,
  output logic                         rxSecondary,
  output logic [NUM_REGS*VAL_BITS-1:0] ctlRegs
);
  chp_strobe_t stb;

  chp_ctrl #(.FRAME_BITS(FRAME_BITS), .HALF_CYCLES(HALF_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterSel(masterSel), .slotSel(slotSel),
    .hwCtl(hwCtl), .pwrDownN(pwrDownN), .fsIn(fsIn),
    .sclk(sclk), .fsOut(fsOut), .stb(stb)
  );

  chp_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .din(din), .txWord(txWord),
    .dout(dout), .rxWord(rxWord), .rxValid(rxValid),
    .rxSecondary(rxSecondary), .ctlRegs(ctlRegs)
  );
endmodule

// File: rtl/codec_host_port_chk.sv
`timescale 1ns/1ps
module codec_host_port_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  masterSel,
  input logic                  pwrDownN,
  input logic                  sclk,
  input logic                  fsOut,
  input logic                  dout,
  input logic                  rxValid,
  input logic [NUM_REGS*7-1:0] ctlRegs
);
  assert_fs_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    (masterSel && $rose(sclk) && !$past(fsOut)) |-> fsOut);

  assert_fs_on_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fsOut) |-> $rose(sclk));

  assert_slave_fs_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !masterSel |-> fsOut);

  assert_dout_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dout) |-> $rose(sclk));

  assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_pd_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> ($stable(sclk) && $stable(ctlRegs)));
endmodule

bind codec_host_port codec_host_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .masterSel(masterSel), .pwrDownN(pwrDownN),
  .sclk(sclk), .fsOut(fsOut), .dout(dout), .rxValid(rxValid), .ctlRegs(ctlRegs)
);

// File: tb/codec_host_port_test.sv
`timescale 1ns/1ps
module codec_host_port_test;
  localparam int FB = 40;
  localparam int NR = 4;

  logic clk = 1'b0, rstN = 1'b0, masterSel = 1'b1, slotSel = 1'b0;
  logic [1:0] hwCtl = 2'b00;
  logic pwrDownN = 1'b1, fsIn = 1'b1, din = 1'b0;
  logic [15:0] txWord = '0;
  logic sclk, fsOut, dout, rxValid, rxSecondary;
  logic [15:0] rxWord;
  logic [NR*7-1:0] ctlRegs;

  int total = 0, bad = 0;

  typedef struct packed {
    logic [15:0] dinW, txW, expDout;
    logic pwrTest;
  } frame_t;
  typedef struct packed { logic [15:0] w; logic sec; } rx_t;

  frame_t frameQ[$];
  string  tagQ[$];
  rx_t    rxQ[$];

  always #4 clk = ~clk;

  codec_host_port #(.FRAME_BITS(FB), .HALF_CYCLES(2), .NUM_REGS(NR)) uut (
    .clk(clk), .rstN(rstN), .masterSel(masterSel), .slotSel(slotSel),
    .hwCtl(hwCtl), .pwrDownN(pwrDownN), .fsIn(fsIn), .din(din),
    .txWord(txWord), .sclk(sclk), .fsOut(fsOut), .dout(dout),
    .rxWord(rxWord), .rxValid(rxValid), .rxSecondary(rxSecondary),
    .ctlRegs(ctlRegs)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] regVal(input int i);
    return ctlRegs[i*7 +: 7];
  endfunction

  function automatic logic [15:0] ctlWord(input logic [7:0] a, input logic [6:0] v);
    return {a, v, 1'b1};
  endfunction

  // driver: one frame of stimulus plus what it must produce
  task automatic pushFrame(input logic [15:0] dinW, input logic [15:0] txW,
                           input logic [15:0] expDout, input string tag,
                           input bit expRx, input bit rxSec, input bit pwrTest = 1'b0);
    frame_t f;
    rx_t r;
    f.dinW = dinW; f.txW = txW; f.expDout = expDout; f.pwrTest = pwrTest;
    frameQ.push_back(f);
    tagQ.push_back(tag);
    if (expRx) begin
      r.w = dinW; r.sec = rxSec;
      rxQ.push_back(r);
    end
  endtask

  // monitor for received words
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (rxQ.size() == 0) begin
        check(1'b0, "R5 unexpected rxValid", {16'h0, rxWord}, 32'h0);
      end else begin
        rx_t r;
        r = rxQ.pop_front();
        check(rxWord == r.w, "R5 rxWord", {16'h0, rxWord}, {16'h0, r.w});
        check(rxSecondary == r.sec, "R5 rxSecondary", {31'h0, rxSecondary}, {31'h0, r.sec});
      end
    end
  end

  task automatic doReset(input logic ms, input logic slot, input logic [1:0] hw);
    @(negedge clk);
    rstN = 1'b0; masterSel = ms; slotSel = slot; hwCtl = hw;
    fsIn = 1'b1; din = 1'b0; pwrDownN = 1'b1;
    repeat (3) @(negedge clk);
    check(regVal(0) == 7'd80 && regVal(1) == 7'h7F && regVal(2) == 7'd0 && regVal(3) == 7'd1,
          "R9 register defaults", {4'h0, ctlRegs}, {4'h0, 7'd1, 7'd0, 7'h7F, 7'd80});
    check(dout == 1'b0 && fsOut == 1'b1 && rxValid == 1'b0, "R9 reset outputs",
          {29'h0, dout, fsOut, rxValid}, 32'h2);
    rstN = 1'b1;
  endtask

  task automatic runFrames(input logic ms, input logic slot);
    frame_t cur;
    string tag;
    logic [15:0] cap;
    bit fsBad, idleBad;
    int base;
    base = slot ? 16 : 0;
    cur = '0; cap = '0; tag = "";
    txWord = frameQ[0].txW;
    if (!ms) begin
      @(posedge sclk); #2;
      fsIn = 1'b0;
    end
    while (frameQ.size() > 0) begin
      fsBad = 1'b0; idleBad = 1'b0;
      for (int b = 0; b < FB; b++) begin
        int pos;
        @(posedge sclk); #2;
        if (b == 0) begin
          cur = frameQ.pop_front();
          tag = tagQ.pop_front();
        end
        if (ms) begin
          if (fsOut != (b != 0)) fsBad = 1'b1;
        end else begin
          if (b == 0) fsIn = 1'b1;
          if (b == FB - 1 && frameQ.size() > 0) fsIn = 1'b0;
          if (fsOut != 1'b1) fsBad = 1'b1;
        end
        pos = b - base;
        din = (pos >= 0 && pos < 16) ? cur.dinW[15 - pos] : 1'b0;
        if (cur.pwrTest && b == 5) begin
          logic sSnap;
          logic [NR*7-1:0] rSnap;
          bit held;
          sSnap = sclk; rSnap = ctlRegs; held = 1'b1;
          pwrDownN = 1'b0;
          repeat (40) begin
            @(negedge clk);
            if (sclk != sSnap || ctlRegs != rSnap) held = 1'b0;
          end
          check(held, "R10 frozen during power-down", {31'h0, held}, 32'h1);
          pwrDownN = 1'b1;
        end
        @(negedge sclk); #2;
        if (pos >= 0 && pos < 16) cap = {cap[14:0], dout};
        else if (dout != 1'b0) idleBad = 1'b1;
        if (pos == 15) begin
          check(cap == cur.expDout, tag, {16'h0, cap}, {16'h0, cur.expDout});
          if (frameQ.size() > 0) txWord = frameQ[0].txW;
        end
      end
      check(!fsBad, ms ? "R1 master frame sync" : "R2 slave frame sync",
            {31'h0, fsBad}, 32'h0);
      check(!idleBad, "R4 dout idle outside slot", {31'h0, idleBad}, 32'h0);
    end
    repeat (4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // master, first slot, software mode
    pushFrame(16'hA5C2, 16'h1234, 16'h1234, "R3 slot0 dout word", 1'b1, 1'b0);
    pushFrame(ctlWord(8'h01, 7'h25), 16'h5555, 16'h5555, "R6 control frame dout", 1'b0, 1'b0);
    pushFrame(16'h3C3C, 16'h7777, ctlWord(8'h01, 7'h25), "R7 readback word", 1'b1, 1'b0);
    pushFrame(ctlWord(8'h09, 7'h11), 16'h1111, 16'h1111, "R6 invalid control frame", 1'b0, 1'b0);
    pushFrame(16'h8000, 16'h2222, ctlWord(8'h09, 7'h00), "R7 invalid readback", 1'b1, 1'b0);
    pushFrame(16'hFFFE, 16'hBEEF, 16'hBEEF, "R10 resumed word", 1'b1, 1'b1, 1'b1);
    doReset(1'b1, 1'b0, 2'b00);
    runFrames(1'b1, 1'b0);
    check(regVal(1) == 7'h25, "R6 register written", {25'h0, regVal(1)}, 32'h25);
    check(regVal(0) == 7'd80 && regVal(2) == 7'd0 && regVal(3) == 7'd1,
          "R7 invalid address ignored", {4'h0, ctlRegs}, {4'h0, 7'd1, 7'd0, 7'h25, 7'd80});

    // master, second slot, hardware mode
    pushFrame(ctlWord(8'h00, 7'h7F), 16'h0F0F, 16'h0F0F, "R4 slot1 dout word", 1'b1, 1'b0);
    pushFrame(16'h1357, 16'hF0F0, 16'hF0F0, "R8 no readback in hw mode", 1'b1, 1'b1);
    doReset(1'b1, 1'b1, 2'b01);
    runFrames(1'b1, 1'b1);
    check(regVal(0) == 7'd80, "R8 registers untouched", {25'h0, regVal(0)}, 32'd80);

    // slave, first slot, software mode
    pushFrame(ctlWord(8'h02, 7'h33), 16'hAAAA, 16'hAAAA, "R2 slave control frame", 1'b0, 1'b0);
    pushFrame(16'h4444, 16'h9999, ctlWord(8'h02, 7'h33), "R7 slave readback", 1'b1, 1'b1);
    pushFrame(16'h6666, 16'h0001, 16'h0001, "R3 slave data word", 1'b1, 1'b0);
    doReset(1'b0, 1'b0, 2'b00);
    runFrames(1'b0, 1'b0);
    check(regVal(2) == 7'h33, "R6 slave register written", {25'h0, regVal(2)}, 32'h33);

    check(rxQ.size() == 0, "R5 all words delivered", rxQ.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule